// File: doc/BRIEF.md
# Slot Reallocation Engine

This block keeps a node's pool of free data slots on a shared time-division medium as a bitmap, one bit per slot index. A local user asks for a channel of a wanted number of slots with a smallest acceptable number. When the pool already covers the wanted count the engine hands the slots over at once. When it does not, the engine borrows the shortfall from peer nodes, nearest peer first, guided by a table of the free-slot counts those peers last advertised. It waits for every borrow answer and then grants the channel, grants a reduced channel, retries, or rejects.

The same engine answers borrow requests that arrive from peers. It gives away as many of its own slots as were asked for, up to what it holds, but never goes below a fixed reserve. Messages to and from peers travel over valid/ready ports. Peer index `i` is the `i`-th nearest peer, so index 0 is the closest. A slot mask of all zeros in any answer means reject.

Top module: `slotRealloc`

## Requirements
- R1: After reset the pool equals the `INIT_POOL` parameter, every entry of the peer table is zero, `chReqReady` and `peerReqReady` are high, and `chDoneValid`, `borReqValid` and `peerRspValid` are low.
- R2: When the pool holds at least `chReqWant` free slots, the engine grants exactly the `chReqWant` lowest-indexed free slots with `chDoneOk` high, removes them from the pool, and issues no borrow request.
- R3: Otherwise the shortfall is wanted minus free. Peers are visited in increasing index. A peer whose table entry is zero is skipped. Each visited peer receives one request carrying the shortfall still open, after which the open shortfall drops by the smaller of itself and that peer's table entry. The scan stops when the open shortfall is zero or the last peer has been visited. If no peer qualifies, no request is issued.
- R4: After the scan the engine accepts one answer per request issued and ORs every answer mask into the pool. A zero mask is a reject. It decides only after all answers are in.
- R5: On deciding, if the pool covers the wanted count the lowest-indexed wanted slots are granted. Otherwise, if the pool holds at least `chReqMin` slots, every free slot is granted. Either way `chDoneOk` is high.
- R6: If neither holds, the engine repeats the scan and wait, up to `MAX_RETRY` extra times. After the last attempt it reports `chDoneOk` low with an all-zero `chDoneMask`.
- R7: Slots borrowed during a request that fails stay in the local pool and serve later channels.
- R8: A peer request for K slots receives `min(K, max(0, free - RESERVE))` of the lowest-indexed free slots. They leave the pool in the same clock edge that loads the answer. An answer of zero slots is a reject. The answer is addressed to the asking peer.
- R9: A status update writes the peer table only while the engine is idle. Updates that arrive while a channel request is being processed are dropped.
- R10: `borReqValid` and `peerRspValid` hold their payload stable until accepted. `chDoneValid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chReqValid | input | 1 | Local channel request present |
| chReqReady | output | 1 | Engine idle, request accepted |
| chReqWant | input | CNT_W | Wanted slot count |
| chReqMin | input | CNT_W | Smallest acceptable slot count |
| chDoneValid | output | 1 | Channel outcome pulse |
| chDoneOk | output | 1 | Channel granted |
| chDoneMask | output | SLOTS | Slots given to the channel |
| statValid | input | 1 | Peer status update present |
| statPeer | input | PEER_W | Peer the update describes |
| statFree | input | CNT_W | Free slots that peer advertises |
| borReqValid | output | 1 | Borrow request to a peer |
| borReqReady | input | 1 | Borrow request taken |
| borReqPeer | output | PEER_W | Peer asked |
| borReqCount | output | CNT_W | Slots asked for |
| borRspValid | input | 1 | Borrow answer present |
| borRspReady | output | 1 | Engine takes borrow answers |
| borRspMask | input | SLOTS | Slots handed over, zero for reject |
| peerReqValid | input | 1 | A peer asks for slots |
| peerReqReady | output | 1 | Peer request accepted |
| peerReqPeer | input | PEER_W | Asking peer |
| peerReqCount | input | CNT_W | Slots it asks for |
| peerRspValid | output | 1 | Answer to a peer present |
| peerRspReady | input | 1 | Answer taken |
| peerRspPeer | output | PEER_W | Peer being answered |
| peerRspMask | output | SLOTS | Slots given away, zero for reject |

## Verification
The properties rely on the environment keeping its side of the protocol. `chReqMin` lies between one and `chReqWant`. Borrow answers carry only slots the node does not already hold. No answer comes without an outstanding request. Peer indices stay below `PEERS`. The bench models the peers itself: each answer it returns is a disjoint slot set picked in advance, it accepts borrow requests under periodic backpressure, and it sends status and channel requests only in the windows the requirements define. The one exception is a status update it sends on purpose while a request is being processed, to prove that such updates are dropped.

// File: rtl/srePkg.sv
package srePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_DECIDE
  } sreState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic startIssue;
    logic sendReq;
    logic skipPeer;
    logic grant;
    logic fail;
    logic retry;
    logic statOpen;
    logic rspOpen;
    logic peerOpen;
  } sreStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic fullMet;
    logic minMet;
    logic peerEligible;
    logic scanDone;
    logic outZero;
    logic retryLeft;
  } sreFlags_t;

endpackage

// File: rtl/sreControl.sv
module sreControl
  import srePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chReqValid,
  output logic       chReqReady,
  input  logic       borReqReady,
  output logic       borReqValid,
  input  sreFlags_t  flags,
  output sreStrobe_t stb
);

  sreState_e stateR, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateR <= ST_IDLE;
    else       stateR <= stateNext;
  end

  always_comb begin
    stateNext   = stateR;
    stb         = '0;
    borReqValid = 1'b0;
    chReqReady  = 1'b0;
    unique case (stateR)
      ST_IDLE: begin
        chReqReady   = 1'b1;
        stb.statOpen = 1'b1;
        stb.peerOpen = 1'b1;
        if (chReqValid) begin
          stb.capture = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (flags.fullMet) begin
          stb.grant = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stb.startIssue = 1'b1;
          stateNext      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (flags.scanDone) begin
          stateNext = ST_WAIT;
        end else if (flags.peerEligible) begin
          borReqValid = 1'b1;
          stb.sendReq = borReqReady;
        end else begin
          stb.skipPeer = 1'b1;
        end
      end
      ST_WAIT: begin
        stb.rspOpen  = 1'b1;
        stb.peerOpen = 1'b1;
        if (flags.outZero) stateNext = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (flags.fullMet || flags.minMet) begin
          stb.grant = 1'b1;
          stateNext = ST_IDLE;
        end else if (flags.retryLeft) begin
          stb.retry = 1'b1;
          stateNext = ST_CHECK;
        end else begin
          stb.fail  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sreDatapath.sv
module sreDatapath
  import srePkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int PEERS     = 4,
  parameter int RESERVE   = 2,
  parameter int MAX_RETRY = 1,
  parameter logic [SLOTS-1:0] INIT_POOL = {{(SLOTS/2){1'b0}}, {(SLOTS-SLOTS/2){1'b1}}},
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int PEER_W = $clog2(PEERS),
  localparam int PTR_W  = $clog2(PEERS + 1),
  localparam int RTY_W  = $clog2(MAX_RETRY + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sreStrobe_t        stb,
  output sreFlags_t         flags,
  input  logic [CNT_W-1:0]  chReqWant,
  input  logic [CNT_W-1:0]  chReqMin,
  output logic              chDoneValid,
  output logic              chDoneOk,
  output logic [SLOTS-1:0]  chDoneMask,
  input  logic              statValid,
  input  logic [PEER_W-1:0] statPeer,
  input  logic [CNT_W-1:0]  statFree,
  output logic [PEER_W-1:0] borReqPeer,
  output logic [CNT_W-1:0]  borReqCount,
  input  logic              borRspValid,
  output logic              borRspReady,
  input  logic [SLOTS-1:0]  borRspMask,
  input  logic              peerReqValid,
  output logic              peerReqReady,
  input  logic [PEER_W-1:0] peerReqPeer,
  input  logic [CNT_W-1:0]  peerReqCount,
  output logic              peerRspValid,
  input  logic              peerRspReady,
  output logic [PEER_W-1:0] peerRspPeer,
  output logic [SLOTS-1:0]  peerRspMask
);

  localparam logic [CNT_W-1:0] RES_C   = CNT_W'(RESERVE);
  localparam logic [PTR_W-1:0] PEERS_C = PTR_W'(PEERS);
  localparam logic [RTY_W-1:0] RTY_C   = RTY_W'(MAX_RETRY);

  function automatic logic [CNT_W-1:0] countSet(input logic [SLOTS-1:0] m);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < SLOTS; i++) acc = acc + CNT_W'(m[i]);
    return acc;
  endfunction

  function automatic logic [SLOTS-1:0] pickLow(input logic [SLOTS-1:0] m,
                                                input logic [CNT_W-1:0] n);
    logic [SLOTS-1:0] sel;
    logic [CNT_W-1:0] taken;
    sel   = '0;
    taken = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (m[i] && (taken < n)) begin
        sel[i] = 1'b1;
        taken  = taken + 1'b1;
      end
    end
    return sel;
  endfunction

  logic [SLOTS-1:0] poolR;
  logic [CNT_W-1:0] peerFreeR [PEERS];
  logic [CNT_W-1:0] wantR, minR, remR;
  logic [PTR_W-1:0] ptrR, outR;
  logic [RTY_W-1:0] retryR;

  logic [CNT_W-1:0] freeCnt, curEntry, cutAmt, spare, giveN, grantN;
  logic [SLOTS-1:0] giveMask, grantMask;
  logic             ptrEnd, peerAccept, rspAccept;

  assign freeCnt  = countSet(poolR);
  assign ptrEnd   = (ptrR >= PEERS_C);
  assign curEntry = ptrEnd ? '0 : peerFreeR[ptrR[PEER_W-1:0]];
  assign cutAmt   = (curEntry < remR) ? curEntry : remR;

  assign flags.fullMet      = (freeCnt >= wantR);
  assign flags.minMet       = (freeCnt >= minR);
  assign flags.scanDone     = ptrEnd || (remR == '0);
  assign flags.peerEligible = (curEntry != '0);
  assign flags.outZero      = (outR == '0);
  assign flags.retryLeft    = (retryR < RTY_C);

  // slots offered to a peer, reserve held back
  assign spare    = (freeCnt > RES_C) ? (freeCnt - RES_C) : '0;
  assign giveN    = (peerReqCount < spare) ? peerReqCount : spare;
  assign giveMask = pickLow(poolR, giveN);

  // slots handed to the local channel
  assign grantN    = flags.fullMet ? wantR : freeCnt;
  assign grantMask = pickLow(poolR, grantN);

  assign peerReqReady = stb.peerOpen && !peerRspValid;
  assign peerAccept   = peerReqReady && peerReqValid;
  assign borRspReady  = stb.rspOpen && (outR != '0);
  assign rspAccept    = borRspReady && borRspValid;

  assign borReqPeer  = ptrR[PEER_W-1:0];
  assign borReqCount = remR;

  // pool bitmap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      poolR <= INIT_POOL;
    end else if (stb.grant) begin
      poolR <= poolR & ~grantMask;
    end else begin
      poolR <= (poolR & ~(peerAccept ? giveMask : '0)) |
               (rspAccept ? borRspMask : '0);
    end
  end

  // advertised free counts of peers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < PEERS; p++) peerFreeR[p] <= '0;
    end else if (stb.statOpen && statValid) begin
      peerFreeR[statPeer] <= statFree;
    end
  end

  // request bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wantR  <= '0;
      minR   <= '0;
      remR   <= '0;
      ptrR   <= '0;
      outR   <= '0;
      retryR <= '0;
    end else begin
      if (stb.capture) begin
        wantR  <= chReqWant;
        minR   <= chReqMin;
        retryR <= '0;
      end
      if (stb.retry) retryR <= retryR + 1'b1;
      if (stb.startIssue) begin
        remR <= wantR - freeCnt;
        ptrR <= '0;
      end else if (stb.sendReq) begin
        remR <= remR - cutAmt;
        ptrR <= ptrR + 1'b1;
      end else if (stb.skipPeer) begin
        ptrR <= ptrR + 1'b1;
      end
      if (stb.sendReq)    outR <= outR + 1'b1;
      else if (rspAccept) outR <= outR - 1'b1;
    end
  end

  // channel outcome pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chDoneValid <= 1'b0;
      chDoneOk    <= 1'b0;
      chDoneMask  <= '0;
    end else begin
      chDoneValid <= stb.grant || stb.fail;
      chDoneOk    <= stb.grant;
      chDoneMask  <= stb.grant ? grantMask : '0;
    end
  end

  // answer to a peer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peerRspValid <= 1'b0;
      peerRspPeer  <= '0;
      peerRspMask  <= '0;
    end else if (peerAccept) begin
      peerRspValid <= 1'b1;
      peerRspPeer  <= peerReqPeer;
      peerRspMask  <= giveMask;
    end else if (peerRspReady) begin
      peerRspValid <= 1'b0;
    end
  end

endmodule

// File: rtl/slotRealloc.sv
module slotRealloc
  import srePkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int PEERS     = 4,
  parameter int RESERVE   = 2,
  parameter int MAX_RETRY = 1,
  parameter logic [SLOTS-1:0] INIT_POOL = {{(SLOTS/2){1'b0}}, {(SLOTS-SLOTS/2){1'b1}}},
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int PEER_W = $clog2(PEERS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chReqValid,
  output logic              chReqReady,
  input  logic [CNT_W-1:0]  chReqWant,
  input  logic [CNT_W-1:0]  chReqMin,
  output logic              chDoneValid,
  output logic              chDoneOk,
  output logic [SLOTS-1:0]  chDoneMask,
  input  logic              statValid,
  input  logic [PEER_W-1:0] statPeer,
  input  logic [CNT_W-1:0]  statFree,
  output logic              borReqValid,
  input  logic              borReqReady,
  output logic [PEER_W-1:0] borReqPeer,
  output logic [CNT_W-1:0]  borReqCount,
  input  logic              borRspValid,
  output logic              borRspReady,
  input  logic [SLOTS-1:0]  borRspMask,
  input  logic              peerReqValid,
  output logic              peerReqReady,
  input  logic [PEER_W-1:0] peerReqPeer,
  input  logic [CNT_W-1:0]  peerReqCount,
  output logic              peerRspValid,
  input  logic              peerRspReady,
  output logic [PEER_W-1:0] peerRspPeer,
  output logic [SLOTS-1:0]  peerRspMask
);

  sreStrobe_t stb;
  sreFlags_t  flags;

  sreControl i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .chReqValid (chReqValid),
    .chReqReady (chReqReady),
    .borReqReady(borReqReady),
    .borReqValid(borReqValid),
    .flags      (flags),
    .stb        (stb)
  );

  sreDatapath #(
    .SLOTS    (SLOTS),
    .PEERS    (PEERS),
    .RESERVE  (RESERVE),
    .MAX_RETRY(MAX_RETRY),
    .INIT_POOL(INIT_POOL)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .flags       (flags),
    .chReqWant   (chReqWant),
    .chReqMin    (chReqMin),
    .chDoneValid (chDoneValid),
    .chDoneOk    (chDoneOk),
    .chDoneMask  (chDoneMask),
    .statValid   (statValid),
    .statPeer    (statPeer),
    .statFree    (statFree),
    .borReqPeer  (borReqPeer),
    .borReqCount (borReqCount),
    .borRspValid (borRspValid),
    .borRspReady (borRspReady),
    .borRspMask  (borRspMask),
    .peerReqValid(peerReqValid),
    .peerReqReady(peerReqReady),
    .peerReqPeer (peerReqPeer),
    .peerReqCount(peerReqCount),
    .peerRspValid(peerRspValid),
    .peerRspReady(peerRspReady),
    .peerRspPeer (peerRspPeer),
    .peerRspMask (peerRspMask)
  );

endmodule

// File: rtl/sreChecker.sv
module sreChecker #(
  parameter int SLOTS = 16,
  parameter int PEERS = 4,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int PEER_W = $clog2(PEERS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              chReqReady,
  input logic              chDoneValid,
  input logic              chDoneOk,
  input logic [SLOTS-1:0]  chDoneMask,
  input logic              borReqValid,
  input logic              borReqReady,
  input logic [PEER_W-1:0] borReqPeer,
  input logic [CNT_W-1:0]  borReqCount,
  input logic              borRspReady,
  input logic [CNT_W-1:0]  peerReqCount,
  input logic              peerRspValid,
  input logic              peerRspReady,
  input logic [SLOTS-1:0]  peerRspMask
);

  AST_BORREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    borReqValid && !borReqReady |=> borReqValid && $stable(borReqPeer) && $stable(borReqCount)); // R10

  AST_PEERRSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    peerRspValid && !peerRspReady |=> peerRspValid && $stable(peerRspMask)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    chDoneValid |=> !chDoneValid); // R10

  AST_GIVE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(peerRspValid) |-> ($countones(peerRspMask) <= int'($past(peerReqCount)))); // R8

  AST_FAIL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    chDoneValid && !chDoneOk |-> (chDoneMask == '0)); // R6

  AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    borReqValid |-> (borReqCount != '0) && !chReqReady); // R3

  AST_RSP_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    borRspReady |-> !borReqValid && !chReqReady); // R4

endmodule

bind slotRealloc sreChecker #(.SLOTS(SLOTS), .PEERS(PEERS)) i_sreChecker (
  .clk         (clk),
  .rstN        (rstN),
  .chReqReady  (chReqReady),
  .chDoneValid (chDoneValid),
  .chDoneOk    (chDoneOk),
  .chDoneMask  (chDoneMask),
  .borReqValid (borReqValid),
  .borReqReady (borReqReady),
  .borReqPeer  (borReqPeer),
  .borReqCount (borReqCount),
  .borRspReady (borRspReady),
  .peerReqCount(peerReqCount),
  .peerRspValid(peerRspValid),
  .peerRspReady(peerRspReady),
  .peerRspMask (peerRspMask)
);

// File: tb/test_slotRealloc.sv
`timescale 1ns/1ps
module test_slotRealloc;

  localparam int SLOTS  = 16;
  localparam int PEERS  = 4;
  localparam int RESV   = 2;
  localparam int MAXR   = 1;
  localparam logic [SLOTS-1:0] INIT = 16'h00FF;
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int PEER_W = $clog2(PEERS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic              chReqValid = 0, chReqReady;
  logic [CNT_W-1:0]  chReqWant = '0, chReqMin = '0;
  logic              chDoneValid, chDoneOk;
  logic [SLOTS-1:0]  chDoneMask;
  logic              statValid = 0;
  logic [PEER_W-1:0] statPeer = '0;
  logic [CNT_W-1:0]  statFree = '0;
  logic              borReqValid, borReqReady = 0;
  logic [PEER_W-1:0] borReqPeer;
  logic [CNT_W-1:0]  borReqCount;
  logic              borRspValid = 0, borRspReady;
  logic [SLOTS-1:0]  borRspMask = '0;
  logic              peerReqValid = 0, peerReqReady;
  logic [PEER_W-1:0] peerReqPeer = '0;
  logic [CNT_W-1:0]  peerReqCount = '0;
  logic              peerRspValid, peerRspReady = 1'b1;
  logic [PEER_W-1:0] peerRspPeer;
  logic [SLOTS-1:0]  peerRspMask;

  slotRealloc #(.SLOTS(SLOTS), .PEERS(PEERS), .RESERVE(RESV), .MAX_RETRY(MAXR),
                .INIT_POOL(INIT)) i_slotRealloc (.*);

  int checks = 0;
  int failures = 0;

  // behavioural model state
  logic [SLOTS-1:0] mPool;
  int               mTable [PEERS];
  int               expPeer[$];
  int               expCnt[$];
  logic [SLOTS-1:0] rspPlan[$];
  logic [SLOTS-1:0] rspQ[$];

  bit               doneFlag = 0;
  logic             gotOk;
  logic [SLOTS-1:0] gotMask;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [SLOTS-1:0] m);
    int c = 0;
    for (int i = 0; i < SLOTS; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic logic [SLOTS-1:0] lowN(input logic [SLOTS-1:0] m, input int n);
    logic [SLOTS-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < SLOTS; i++) if (m[i] && k < n) begin r[i] = 1'b1; k++; end
    return r;
  endfunction

  // peer agent: takes borrow requests under backpressure, answers in order
  int  tick = 0;
  int  pend = 0;
  bit  rspAcc = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rspAcc) begin
        void'(rspQ.pop_front());
        pend--;
        rspAcc = 0;
      end
      borReqReady = (tick % 3) != 2;
      tick++;
      if (rstN && borReqValid && borReqReady) begin
        if (expPeer.size() == 0) begin
          chk(0, "R3", "unexpected borrow request peer", borReqPeer, 0);
        end else begin
          int ep, ec;
          ep = expPeer.pop_front();
          ec = expCnt.pop_front();
          chk(borReqPeer == PEER_W'(ep), "R3", "borrow peer", borReqPeer, ep);
          chk(borReqCount == CNT_W'(ec), "R3", "borrow count", borReqCount, ec);
          pend++;
        end
      end
      if (pend > 0 && rspQ.size() > 0) begin
        borRspValid = 1'b1;
        borRspMask  = rspQ[0];
      end else begin
        borRspValid = 1'b0;
        borRspMask  = '0;
      end
      if (borRspValid && borRspReady) rspAcc = 1;
    end
  end

  // outcome monitor
  initial begin
    forever begin
      @(negedge clk);
      if (chDoneValid) begin
        doneFlag = 1;
        gotOk    = chDoneOk;
        gotMask  = chDoneMask;
      end
    end
  end

  task automatic setStat(input int p, input int f);
    @(negedge clk);
    statValid = 1'b1;
    statPeer  = PEER_W'(p);
    statFree  = CNT_W'(f);
    @(negedge clk);
    statValid = 1'b0;
    mTable[p] = f;
  endtask

  task automatic peerAsk(input int p, input int k, input string rq);
    int sp, n;
    logic [SLOTS-1:0] em;
    sp = popc(mPool) - RESV;
    if (sp < 0) sp = 0;
    n  = (k < sp) ? k : sp;
    em = lowN(mPool, n);
    mPool = mPool & ~em;
    @(negedge clk);
    peerReqValid = 1'b1;
    peerReqPeer  = PEER_W'(p);
    peerReqCount = CNT_W'(k);
    while (!peerReqReady) @(negedge clk);
    @(negedge clk);
    peerReqValid = 1'b0;
    chk(peerRspValid == 1'b1, rq, "peer answer valid", peerRspValid, 1);
    chk(peerRspMask == em, rq, "peer answer mask", peerRspMask, em);
    chk(peerRspPeer == PEER_W'(p), rq, "peer answer addressee", peerRspPeer, p);
  endtask

  task automatic runChannel(input int want, input int minv, input int dropPeer, input string rq);
    bit expOk = 0;
    bit decided = 0;
    logic [SLOTS-1:0] expMask = '0;
    for (int a = 0; a <= MAXR && !decided; a++) begin
      int f, rem;
      f = popc(mPool);
      if (f >= want) begin
        expOk = 1; expMask = lowN(mPool, want); decided = 1;
      end else begin
        rem = want - f;
        for (int p = 0; p < PEERS; p++) begin
          if (rem == 0) break;
          if (mTable[p] > 0) begin
            logic [SLOTS-1:0] m;
            expPeer.push_back(p);
            expCnt.push_back(rem);
            rem = rem - ((mTable[p] < rem) ? mTable[p] : rem);
            m = rspPlan.pop_front();
            rspQ.push_back(m);
            mPool = mPool | m;
          end
        end
        f = popc(mPool);
        if (f >= want) begin
          expOk = 1; expMask = lowN(mPool, want); decided = 1;
        end else if (f >= minv) begin
          expOk = 1; expMask = mPool; decided = 1;
        end
      end
    end
    mPool = mPool & ~expMask;
    doneFlag = 0;
    @(negedge clk);
    chReqValid = 1'b1;
    chReqWant  = CNT_W'(want);
    chReqMin   = CNT_W'(minv);
    while (!chReqReady) @(negedge clk);
    @(negedge clk);
    chReqValid = 1'b0;
    if (dropPeer >= 0) begin
      statValid = 1'b1;
      statPeer  = PEER_W'(dropPeer);
      statFree  = CNT_W'(7);
      @(negedge clk);
      statValid = 1'b0;
    end
    while (!doneFlag) @(negedge clk);
    chk(gotOk == expOk, rq, "channel ok", gotOk, expOk);
    chk(gotMask == expMask, rq, "channel mask", gotMask, expMask);
    chk(expPeer.size() == 0, rq, "borrow requests missing", expPeer.size(), 0);
    chk(rspQ.size() == 0, rq, "borrow answers not taken", rspQ.size(), 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    mPool = INIT;
    for (int p = 0; p < PEERS; p++) mTable[p] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    chk(chReqReady == 1'b1, "R1", "chReqReady in reset", chReqReady, 1);
    chk(peerReqReady == 1'b1, "R1", "peerReqReady in reset", peerReqReady, 1);
    chk(chDoneValid == 1'b0, "R1", "chDoneValid in reset", chDoneValid, 0);
    chk(borReqValid == 1'b0, "R1", "borReqValid in reset", borReqValid, 0);
    chk(peerRspValid == 1'b0, "R1", "peerRspValid in reset", peerRspValid, 0);
    rstN = 1'b1;

    // R2: pool covers the request, lowest slots, no borrowing
    runChannel(3, 3, -1, "R2");
    // R8: giving to peers, reserve respected, reject when nothing spare
    peerAsk(1, 2, "R8");
    peerAsk(3, 5, "R8");
    peerAsk(0, 3, "R8");
    // status while idle
    setStat(1, 2);
    setStat(2, 5);
    setStat(3, 4);
    // R3 R4: nearest-first scan, skip empty peer 0; R9: status sent while busy
    runChannel(6, 6, 0, "R3");
    // R9: peer 0 still zero so not asked; R5 partial grant after R6 retry
    rspPlan.push_back(16'h0000); rspPlan.push_back(16'h1000);
    rspPlan.push_back(16'h2000); rspPlan.push_back(16'h0000);
    runChannel(4, 2, -1, "R5");
    // R6: all rejects, retries exhausted
    for (int i = 0; i < 4; i++) rspPlan.push_back(16'h0000);
    runChannel(3, 3, -1, "R6");
    // R7: borrowed slot kept after failure, then used locally
    rspPlan.push_back(16'h4000);
    for (int i = 0; i < 3; i++) rspPlan.push_back(16'h0000);
    runChannel(5, 5, -1, "R7");
    runChannel(1, 1, -1, "R7");
    // R3: no qualifying peer issues no request
    setStat(1, 0);
    setStat(2, 0);
    setStat(3, 0);
    runChannel(2, 1, -1, "R3");
    // R3: only the farthest peer qualifies
    setStat(3, 3);
    rspPlan.push_back(16'h8001);
    runChannel(2, 2, -1, "R3");
    // R8: empty pool rejects
    peerAsk(2, 1, "R8");
    repeat (3) @(negedge clk);
    finishRun();
  end

  // the run above with the shipped plan for the first borrow test
  initial begin
    rspPlan.push_back(16'h0300);
    rspPlan.push_back(16'h0C00);
  end

endmodule